// File: doc/BRIEF.md
# Control-Flow Next-PC Unit

This unit works out where the program counter goes after a control-flow instruction and how many cycles that instruction takes. The program counter counts words. Decode hands the unit one operation class. Alongside it come the current PC and every operand the class might need: a signed relative displacement, a status-bit selector with a polarity, the 8-bit status register, the 16-bit Z pointer, the return address already popped from the stack, a skip condition, and a flag that says whether the following instruction is two words long. The unit does not fetch, decode or touch stack memory.

The unit takes one operation per clock when `op_valid` is high. It returns the result one clock later with `res_valid` high. The result carries the next PC, a taken flag, the cycle count for that outcome, and a strobe that asks the core to set the global interrupt enable flag. The PC and displacement widths are parameters, and the PC wraps modulo 2^PC_W. The default of 12 bits gives a 4096-word space. The status bit layout is fixed where the signed test depends on it: N is bit 2 and V is bit 3.

Operation class encoding on `op_class`:
- 0: sequential
- 1: relative jump
- 2: indirect jump
- 3: relative call
- 4: indirect call
- 5: return
- 6: return from interrupt
- 7: branch on a flag
- 8: signed branch
- 9: skip

Codes 10 to 15 are reserved.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `res_valid`, `next_pc`, `taken`, `cycles` and `ie_set` are all zero.
- R2: An operation presented with `op_valid` high gives `res_valid` high on the next cycle. A cycle with `op_valid` low gives `res_valid` low on the next cycle, and `next_pc`, `taken`, `cycles` and `ie_set` keep their values.
- R3: Class 0 and the reserved classes 10 to 15 give next PC = PC + 1, taken 0, cycles 1.
- R4: Relative jump (class 1) and relative call (class 3) give PC + k + 1, where k is `rel_off` read as two's complement. Taken is 1. The jump takes 2 cycles and the call takes 3.
- R5: Indirect jump (class 2) and indirect call (class 4) load the PC from the low PC_W bits of `zptr`. Taken is 1. The jump takes 2 cycles and the call takes 3.
- R6: Return (class 5) and return from interrupt (class 6) load the PC from `ret_addr`. Both take 4 cycles and give taken 1. `ie_set` is 1 only for class 6 and is 0 for every other class.
- R7: Flag branch (class 7) is taken when `sreg[flag_sel]` equals `flag_pol`. A taken branch gives PC + k + 1 in 2 cycles. A branch that is not taken gives PC + 1 in 1 cycle with taken 0.
- R8: Signed branch (class 8) works the same way as R7, but it tests N XOR V, which is `sreg[2]` XOR `sreg[3]`. With `flag_pol` 0 it branches on greater-or-equal (XOR is 0). With `flag_pol` 1 it branches on less-than (XOR is 1).
- R9: Skip (class 9) with `skip_cond` high gives taken 1. It gives PC + 3 in 3 cycles when `next_is_long` is high, and PC + 2 in 2 cycles when it is low. With `skip_cond` low it gives PC + 1, 1 cycle and taken 0.
- R10: Every computed next PC wraps modulo 2^PC_W, both past the top of the space and below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_class | input | 4 | Control-flow operation class |
| cur_pc | input | PC_W | Word address of the current instruction |
| rel_off | input | OFF_W | Signed relative displacement |
| flag_sel | input | 3 | Status bit tested by a flag branch |
| flag_pol | input | 1 | Branch when tested value equals this |
| sreg | input | 8 | Status register |
| zptr | input | 16 | Z pointer for indirect targets |
| ret_addr | input | PC_W | Return address popped from the stack |
| skip_cond | input | 1 | Skip condition evaluated by decode |
| next_is_long | input | 1 | Following instruction is two words |
| res_valid | output | 1 | Result valid |
| next_pc | output | PC_W | Next program counter |
| taken | output | 1 | Control flow left the sequential path |
| cycles | output | 3 | Cycle count of the instruction |
| ie_set | output | 1 | Request to set the global interrupt enable |

## Verification
The bench builds the unit with PC_W = 6 and OFF_W = 6, so the whole program space has 64 words. At that size it can sweep every PC against every displacement for relative jumps and calls. Wrap in both directions therefore comes up many times, not as one hand-picked case. It also sweeps every status byte against every bit selector and both polarities for flag and signed branches, and every PC under each skip combination. The upper Z bits above the 6-bit PC are exercised, which confirms they are dropped.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int ZPTR_W  = 16;
    localparam int SREG_W  = 8;
    localparam int CYC_W   = 3;
    localparam int SR_NEG  = 2;
    localparam int SR_OVF  = 3;

    typedef logic [CYC_W-1:0] cyc_t;

    typedef enum logic [3:0] {
        CF_SEQ    = 4'd0,
        CF_RJMP   = 4'd1,
        CF_IJMP   = 4'd2,
        CF_RCALL  = 4'd3,
        CF_ICALL  = 4'd4,
        CF_RET    = 4'd5,
        CF_RETI   = 4'd6,
        CF_BRFLAG = 4'd7,
        CF_BRSIGN = 4'd8,
        CF_SKIP   = 4'd9
    } cf_op_e;

    typedef enum logic [2:0] {
        TS_INC1 = 3'd0,
        TS_INC2 = 3'd1,
        TS_INC3 = 3'd2,
        TS_REL  = 3'd3,
        TS_ZPTR = 3'd4,
        TS_RET  = 3'd5
    } tgt_sel_e;

    typedef struct packed {
        logic     taken;
        cyc_t     cycles;
        logic     ie_set;
        tgt_sel_e sel;
    } cf_decision_t;

    function automatic logic signed_lt(input logic [SREG_W-1:0] s);
        return s[SR_NEG] ^ s[SR_OVF];
    endfunction

    function automatic cf_decision_t seq_decision();
        cf_decision_t d;
        d.taken  = 1'b0;
        d.cycles = cyc_t'(1);
        d.ie_set = 1'b0;
        d.sel    = TS_INC1;
        return d;
    endfunction

    function automatic cf_decision_t jump_decision(input tgt_sel_e sel, input int unsigned cyc);
        cf_decision_t d;
        d.taken  = 1'b1;
        d.cycles = cyc_t'(cyc);
        d.ie_set = 1'b0;
        d.sel    = sel;
        return d;
    endfunction

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
(
    input  logic [3:0]        op_class,
    input  logic [2:0]        flag_sel,
    input  logic              flag_pol,
    input  logic [SREG_W-1:0] sreg,
    input  logic              skip_cond,
    output logic              cond_met
);

    logic flag_val;

    always_comb begin
        flag_val = sreg[flag_sel];
    end

    always_comb begin
        case (op_class)
            CF_BRFLAG: cond_met = (flag_val == flag_pol);
            CF_BRSIGN: cond_met = (signed_lt(sreg) == flag_pol);
            CF_SKIP:   cond_met = skip_cond;
            default:   cond_met = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_decide.sv
module npc_decide
    import npc_pkg::*;
(
    input  logic [3:0]   op_class,
    input  logic         cond_met,
    input  logic         next_is_long,
    output cf_decision_t dec
);

    always_comb begin
        dec = seq_decision();
        case (op_class)
            CF_RJMP:  dec = jump_decision(TS_REL, 2);
            CF_IJMP:  dec = jump_decision(TS_ZPTR, 2);
            CF_RCALL: dec = jump_decision(TS_REL, 3);
            CF_ICALL: dec = jump_decision(TS_ZPTR, 3);
            CF_RET:   dec = jump_decision(TS_RET, 4);
            CF_RETI: begin
                dec        = jump_decision(TS_RET, 4);
                dec.ie_set = 1'b1;
            end
            CF_BRFLAG, CF_BRSIGN: begin
                if (cond_met) dec = jump_decision(TS_REL, 2);
            end
            CF_SKIP: begin
                if (cond_met) begin
                    if (next_is_long) dec = jump_decision(TS_INC3, 3);
                    else              dec = jump_decision(TS_INC2, 2);
                end
            end
            default: dec = seq_decision();
        endcase
    end

endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
    import npc_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int OFF_W = 12
) (
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [OFF_W-1:0]  rel_off,
    input  logic [ZPTR_W-1:0] zptr,
    input  logic [PC_W-1:0]   ret_addr,
    input  tgt_sel_e          sel,
    output logic [PC_W-1:0]   target
);

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] z_tgt;

    generate
        if (OFF_W >= PC_W) begin : g_off_trunc
            assign off_ext = rel_off[PC_W-1:0];
        end else begin : g_off_sext
            assign off_ext = {{(PC_W-OFF_W){rel_off[OFF_W-1]}}, rel_off};
        end
        if (ZPTR_W >= PC_W) begin : g_z_trunc
            assign z_tgt = zptr[PC_W-1:0];
        end else begin : g_z_zext
            assign z_tgt = {{(PC_W-ZPTR_W){1'b0}}, zptr};
        end
    endgenerate

    always_comb begin
        case (sel)
            TS_INC2: target = cur_pc + PC_W'(2);
            TS_INC3: target = cur_pc + PC_W'(3);
            TS_REL:  target = cur_pc + off_ext + PC_W'(1);
            TS_ZPTR: target = z_tgt;
            TS_RET:  target = ret_addr;
            default: target = cur_pc + PC_W'(1);
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int OFF_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_class,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [OFF_W-1:0]  rel_off,
    input  logic [2:0]        flag_sel,
    input  logic              flag_pol,
    input  logic [7:0]        sreg,
    input  logic [15:0]       zptr,
    input  logic [PC_W-1:0]   ret_addr,
    input  logic              skip_cond,
    input  logic              next_is_long,
    output logic              res_valid,
    output logic [PC_W-1:0]   next_pc,
    output logic              taken,
    output logic [2:0]        cycles,
    output logic              ie_set
);

    logic            cond_met;
    cf_decision_t    dec;
    logic [PC_W-1:0] target;

    npc_cond_eval u_cond (
        .op_class  (op_class),
        .flag_sel  (flag_sel),
        .flag_pol  (flag_pol),
        .sreg      (sreg),
        .skip_cond (skip_cond),
        .cond_met  (cond_met)
    );

    npc_decide u_decide (
        .op_class     (op_class),
        .cond_met     (cond_met),
        .next_is_long (next_is_long),
        .dec          (dec)
    );

    npc_target_gen #(
        .PC_W  (PC_W),
        .OFF_W (OFF_W)
    ) u_target (
        .cur_pc   (cur_pc),
        .rel_off  (rel_off),
        .zptr     (zptr),
        .ret_addr (ret_addr),
        .sel      (dec.sel),
        .target   (target)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            next_pc   <= '0;
            taken     <= 1'b0;
            cycles    <= '0;
            ie_set    <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                next_pc <= target;
                taken   <= dec.taken;
                cycles  <= dec.cycles;
                ie_set  <= dec.ie_set;
            end
        end
    end

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int PC_W  = 12,
    parameter int OFF_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [3:0]        op_class,
    input logic [PC_W-1:0]   cur_pc,
    input logic [15:0]       zptr,
    input logic [PC_W-1:0]   ret_addr,
    input logic              skip_cond,
    input logic              next_is_long,
    input logic              res_valid,
    input logic [PC_W-1:0]   next_pc,
    input logic              taken,
    input logic [2:0]        cycles,
    input logic              ie_set
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && $stable(next_pc) && $stable(cycles) && $stable(taken))); // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_class == 4'd0) |=>
            (next_pc == PC_W'($past(cur_pc) + PC_W'(1)) && cycles == 3'd1 && !taken)); // R3

    AST_CYCLE_RANGE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (cycles >= 3'd1 && cycles <= 3'd4)); // R4

    AST_INDIRECT_JUMP: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_class == 4'd2) |=>
            (next_pc == $past(zptr[PC_W-1:0]) && cycles == 3'd2 && taken)); // R5

    AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_class == 4'd5 || op_class == 4'd6)) |=>
            (next_pc == $past(ret_addr) && cycles == 3'd4)); // R6

    AST_IE_ONLY_RETI: assert property (@(posedge clk) disable iff (rst)
        (res_valid && ie_set) |-> ($past(op_valid) && $past(op_class) == 4'd6)); // R6

    AST_LONG_SKIP: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_class == 4'd9 && skip_cond && next_is_long) |=>
            (next_pc == PC_W'($past(cur_pc) + PC_W'(3)) && cycles == 3'd3)); // R9

    AST_NOT_TAKEN_SHORT: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !taken) |-> (cycles == 3'd1)); // R9

endmodule

bind npc_unit npc_unit_chk #(
    .PC_W  (PC_W),
    .OFF_W (OFF_W)
) u_npc_unit_chk (
    .clk          (clk),
    .rst          (rst),
    .op_valid     (op_valid),
    .op_class     (op_class),
    .cur_pc       (cur_pc),
    .zptr         (zptr),
    .ret_addr     (ret_addr),
    .skip_cond    (skip_cond),
    .next_is_long (next_is_long),
    .res_valid    (res_valid),
    .next_pc      (next_pc),
    .taken        (taken),
    .cycles       (cycles),
    .ie_set       (ie_set)
);

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
module npc_unit_bench;

    localparam int PCW = 6;
    localparam int OFW = 6;
    localparam int MOD = 1 << PCW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           op_valid = 1'b0;
    logic [3:0]     op_class = '0;
    logic [PCW-1:0] cur_pc = '0;
    logic [OFW-1:0] rel_off = '0;
    logic [2:0]     flag_sel = '0;
    logic           flag_pol = 1'b0;
    logic [7:0]     sreg = '0;
    logic [15:0]    zptr = '0;
    logic [PCW-1:0] ret_addr = '0;
    logic           skip_cond = 1'b0;
    logic           next_is_long = 1'b0;
    logic           res_valid;
    logic [PCW-1:0] next_pc;
    logic           taken;
    logic [2:0]     cycles;
    logic           ie_set;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    npc_unit #(.PC_W(PCW), .OFF_W(OFW)) u_npc_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_class(op_class),
        .cur_pc(cur_pc), .rel_off(rel_off), .flag_sel(flag_sel), .flag_pol(flag_pol),
        .sreg(sreg), .zptr(zptr), .ret_addr(ret_addr), .skip_cond(skip_cond),
        .next_is_long(next_is_long), .res_valid(res_valid), .next_pc(next_pc),
        .taken(taken), .cycles(cycles), .ie_set(ie_set)
    );

    function automatic int wrapm(input int x);
        return ((x % MOD) + MOD) % MOD;
    endfunction

    function automatic int sext(input int v);
        return (v >= (1 << (OFW - 1))) ? v - (1 << OFW) : v;
    endfunction

    task automatic check(input string tag, input bit v, input int pc, input bit tk,
                         input int cyc, input bit ie);
        checks++;
        if (v !== res_valid || pc != int'(next_pc) || tk !== taken ||
            cyc != int'(cycles) || ie !== ie_set) begin
            failures++;
            $display("FAIL %s: got v=%0b pc=%0d tk=%0b cyc=%0d ie=%0b exp v=%0b pc=%0d tk=%0b cyc=%0d ie=%0b",
                     tag, res_valid, next_pc, taken, cycles, ie_set, v, pc, tk, cyc, ie);
        end
    endtask

    task automatic run_op(input string tag, input int op, input int pc, input int off,
                          input int ept, input bit etk, input int ecyc, input bit eie);
        @(negedge clk);
        op_valid = 1'b1;
        op_class = 4'(op);
        cur_pc   = PCW'(pc);
        rel_off  = OFW'(off);
        @(negedge clk);
        check(tag, 1'b1, ept, etk, ecyc, eie);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b0, 0, 1'b0, 0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 1'b0, 0, 1'b0, 0, 1'b0);

        // R3 sequential and reserved codes
        for (int p = 0; p < MOD; p++) run_op("R3 seq", 0, p, 0, wrapm(p + 1), 0, 1, 0);
        for (int op = 10; op < 16; op++) run_op("R3 reserved", op, MOD - 1, 7, 0, 0, 1, 0);

        // R4 and R10 relative jump and call across all PCs and offsets
        for (int p = 0; p < MOD; p++)
            for (int k = 0; k < (1 << OFW); k++) begin
                run_op("R4 R10 rjmp", 1, p, k, wrapm(p + sext(k) + 1), 1, 2, 0);
                run_op("R4 R10 rcall", 3, p, k, wrapm(p + sext(k) + 1), 1, 3, 0);
            end

        // R5 indirect jump and call, upper Z bits dropped
        for (int i = 0; i < 256; i++) begin
            zptr = 16'(i * 257 + 3);
            run_op("R5 ijmp", 2, i % MOD, 0, (i * 257 + 3) % MOD, 1, 2, 0);
            run_op("R5 icall", 4, i % MOD, 0, (i * 257 + 3) % MOD, 1, 3, 0);
        end

        // R6 return and return from interrupt
        for (int a = 0; a < MOD; a++) begin
            ret_addr = PCW'(a);
            run_op("R6 ret", 5, (a * 7) % MOD, 0, a, 1, 4, 0);
            run_op("R6 reti", 6, (a * 7) % MOD, 0, a, 1, 4, 1);
        end

        // R7 flag branch: all status bytes, selectors, polarities
        for (int s = 0; s < 256; s++)
            for (int b = 0; b < 8; b++)
                for (int pol = 0; pol < 2; pol++) begin
                    bit hit;
                    int p;
                    int k;
                    sreg = 8'(s);
                    flag_sel = 3'(b);
                    flag_pol = pol[0];
                    hit = (((s >> b) & 1) == pol);
                    p = (s + b) % MOD;
                    k = s % (1 << OFW);
                    if (hit) run_op("R7 taken", 7, p, k, wrapm(p + sext(k) + 1), 1, 2, 0);
                    else     run_op("R7 not taken", 7, p, k, wrapm(p + 1), 0, 1, 0);
                end

        // R8 signed branch on N xor V
        for (int s = 0; s < 256; s++)
            for (int pol = 0; pol < 2; pol++) begin
                bit lt;
                sreg = 8'(s);
                flag_sel = 3'd0;
                flag_pol = pol[0];
                lt = (((s >> 2) ^ (s >> 3)) & 1) == 1;
                if (lt == pol[0]) run_op("R8 taken", 8, 62, 5, wrapm(62 + 5 + 1), 1, 2, 0);
                else              run_op("R8 not taken", 8, 62, 5, 63, 0, 1, 0);
            end

        // R9 skips over every PC
        for (int p = 0; p < MOD; p++)
            for (int c = 0; c < 2; c++)
                for (int l = 0; l < 2; l++) begin
                    skip_cond = c[0];
                    next_is_long = l[0];
                    if (c == 0)      run_op("R9 no skip", 9, p, 0, wrapm(p + 1), 0, 1, 0);
                    else if (l == 1) run_op("R9 skip long", 9, p, 0, wrapm(p + 3), 1, 3, 0);
                    else             run_op("R9 skip short", 9, p, 0, wrapm(p + 2), 1, 2, 0);
                end

        // R2 idle cycle keeps the last result
        ret_addr = PCW'(41);
        run_op("R2 setup", 6, 0, 0, 41, 1, 4, 1);
        @(negedge clk);
        op_valid = 1'b0;
        op_class = 4'd1;
        cur_pc = PCW'(9);
        rel_off = OFW'(3);
        @(negedge clk);
        check("R2 idle hold", 1'b0, 41, 1'b1, 4, 1'b1);
        @(negedge clk);
        check("R2 idle hold again", 1'b0, 41, 1'b1, 4, 1'b1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule